// File: doc/BRIEF.md
# Banked Memory Map Controller

This block turns every processor access on a 16-bit address bus into exactly one target select for an 8-bit home computer: the boot ROM, main RAM, the 4 KB video/attribute memory, one of three memory-mapped peripheral selects (parallel port chip, timer chip, control register), or nothing at all. Which target answers in the bottom 4 KB and the top 12 KB depends on a small bank state. That state is changed by writes to six dedicated I/O ports.

The four regions split on address bits 15:12. The bottom 4 KB (0x0000-0x0FFF) reads from ROM or RAM, and writes to it always land in RAM. The large middle area (0x1000-0xCFFF) is always RAM. 0x D000-0xDFFF is either video memory or RAM. 0xE000-0xFFFF is either the peripheral window or RAM. A lock command blanks the whole top area until the default configuration is restored. The block drives the selects, a write-inhibit flag for writes that land nowhere, and a read-valid flag. When read-valid is low the system data bus floats and reads as 0xFF. The memories and peripherals sit outside the block.

Top module: `memmap_ctrl`

## Requirements
- R1: After reset, reads of 0x0000-0x0FFF select ROM, 0xD000-0xDFFF selects video memory and 0xE000-0xFFFF selects the peripheral window.
- R2: A write to 0x0000-0x0FFF always selects RAM and never ROM, whatever the low mapping is.
- R3: Any read or write of 0x1000-0xCFFF selects RAM in every bank state.
- R4: In the peripheral window, address bits 3:2 pick the target: 0 = parallel port, 1 = timer, 2 = control register, 3 = nothing. With the default mirroring option the pattern repeats every 16 bytes across the 8 KB window. An access with bits 3:2 = 3 selects nothing, and a write there raises the write inhibit.
- R5: An I/O write to port CMD_BASE+0 maps RAM for reads of the bottom 4 KB. Port CMD_BASE+2 maps ROM there. Both act even while the lock is set.
- R6: Port CMD_BASE+1 maps RAM at both 0xD000-0xDFFF and 0xE000-0xFFFF. Port CMD_BASE+3 maps video memory and the peripheral window back. Neither has any effect while the lock is set.
- R7: Port CMD_BASE+5 sets the lock. While it is set, no select is raised for 0xD000-0xFFFF, reads there have read-valid low, and writes there raise the write inhibit.
- R8: Port CMD_BASE+4 restores the R1 configuration and clears the lock.
- R9: For a video memory access, the attribute flag equals address bit 11. It is 0 for character codes (0xD000-0xD7FF) and 1 for attribute bytes (0xD800-0xDFFF).
- R10: I/O writes to any other port leave the bank state unchanged. This includes CMD_BASE+6.
- R11: At most one select is high at a time. With neither read nor write asserted, no select is high.
- R12: Read-valid is high exactly when a read selects a target. An unmapped read therefore has read-valid low, and the bus reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset to the default map |
| cpu_addr | input | 16 | Memory address |
| cpu_rd | input | 1 | Memory read strobe |
| cpu_wr | input | 1 | Memory write strobe |
| io_wr | input | 1 | I/O write strobe |
| io_port | input | IO_W | I/O port number |
| rom_cs | output | 1 | Boot ROM select |
| ram_cs | output | 1 | Main RAM select |
| vram_cs | output | 1 | Video memory select |
| vram_attr | output | 1 | Video access is in the attribute half |
| pio_cs | output | 1 | Parallel port chip select |
| tmr_cs | output | 1 | Timer chip select |
| ctl_cs | output | 1 | Control register select |
| wr_inhibit | output | 1 | Write has no target and is discarded |
| rd_valid | output | 1 | Read has a driving target |

## Verification
The hardest situation to reach is an upper-area command arriving while the lock is set. Reaching it takes a lock, then a command 1 or 3, then an access to 0xD000-0xFFFF, and finally a restore that must show both the lock cleared and the pre-lock state gone. Directed sequences walk that chain explicitly. The random phase biases its I/O writes toward the eight ports around the command base, so lock, blocked command and restore recur many times in varied orders. It also hits the ignored ports CMD_BASE+6 and CMD_BASE+7 and addresses across all mirrored peripheral copies.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

   typedef enum logic [2:0] {
      CMD_LOW_RAM = 3'd0,
      CMD_HI_RAM  = 3'd1,
      CMD_LOW_ROM = 3'd2,
      CMD_HI_DEV  = 3'd3,
      CMD_DEFAULT = 3'd4,
      CMD_LOCK    = 3'd5
   } bank_cmd_e;

   localparam int NUM_CMDS = 6;

   typedef struct packed {
      logic low_rom;  // bottom 4 KB reads from ROM
      logic hi_dev;   // video memory at D, peripherals at E/F
      logic lock;     // upper 12 KB blanked
   } bank_state_t;

   typedef enum logic [2:0] {
      TGT_NONE,
      TGT_ROM,
      TGT_RAM,
      TGT_VRAM,
      TGT_PIO,
      TGT_TMR,
      TGT_CTL
   } target_e;

endpackage

// File: rtl/memmap_bank_state.sv
module memmap_bank_state
   import memmap_pkg::*;
#(
   parameter int IO_W     = 8,
   parameter int CMD_BASE = 'hE0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            io_wr,
   input  logic [IO_W-1:0] io_port,
   output bank_state_t     state
);
   localparam logic [IO_W-1:0] BASE_P = IO_W'(CMD_BASE);

   logic [IO_W-1:0] ofs;
   logic            hit;
   bank_cmd_e       cmd;
   bank_state_t     nxt;

   assign ofs = io_port - BASE_P;
   assign hit = io_wr && (io_port >= BASE_P) && (ofs < IO_W'(NUM_CMDS));
   assign cmd = bank_cmd_e'(ofs[2:0]);

   always_comb begin
      nxt = state;
      if (hit) begin
         unique case (cmd)
            CMD_LOW_RAM: nxt.low_rom = 1'b0;
            CMD_LOW_ROM: nxt.low_rom = 1'b1;
            CMD_HI_RAM:  if (!state.lock) nxt.hi_dev = 1'b0;
            CMD_HI_DEV:  if (!state.lock) nxt.hi_dev = 1'b1;
            CMD_DEFAULT: nxt = '{low_rom: 1'b1, hi_dev: 1'b1, lock: 1'b0};
            CMD_LOCK:    nxt.lock = 1'b1;
            default:     nxt = state;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= '{low_rom: 1'b1, hi_dev: 1'b1, lock: 1'b0};
      else        state <= nxt;
   end
endmodule

// File: rtl/memmap_periph_dec.sv
module memmap_periph_dec
   import memmap_pkg::*;
#(
   parameter int  ADDR_W        = 16,
   parameter bit  PERIPH_MIRROR = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output target_e           tgt
);
   localparam int WIN_W = 13;  // 8 KB window

   target_e slot;

   always_comb begin
      unique case (addr[3:2])
         2'd0:    slot = TGT_PIO;
         2'd1:    slot = TGT_TMR;
         2'd2:    slot = TGT_CTL;
         default: slot = TGT_NONE;
      endcase
   end

   generate
      if (PERIPH_MIRROR) begin : g_mirror
         assign tgt = slot;
      end else begin : g_single
         assign tgt = (addr[WIN_W-1:4] == '0) ? slot : TGT_NONE;
      end
   endgenerate
endmodule

// File: rtl/memmap_region_dec.sv
module memmap_region_dec
   import memmap_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   input  bank_state_t       state,
   input  target_e           periph_tgt,
   output target_e           tgt
);
   localparam int TOP = ADDR_W - 1;

   logic [3:0] nib;
   assign nib = addr[TOP -: 4];

   always_comb begin
      tgt = TGT_NONE;
      if (rd || wr) begin
         if (nib == 4'h0) begin
            tgt = (!wr && state.low_rom) ? TGT_ROM : TGT_RAM;
         end else if (nib <= 4'hC) begin
            tgt = TGT_RAM;
         end else if (state.lock) begin
            tgt = TGT_NONE;
         end else if (nib == 4'hD) begin
            tgt = state.hi_dev ? TGT_VRAM : TGT_RAM;
         end else begin
            tgt = state.hi_dev ? periph_tgt : TGT_RAM;
         end
      end
   end
endmodule

// File: rtl/memmap_ctrl.sv
module memmap_ctrl
   import memmap_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int IO_W          = 8,
   parameter int CMD_BASE      = 'hE0,
   parameter bit PERIPH_MIRROR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic              io_wr,
   input  logic [IO_W-1:0]   io_port,
   output logic              rom_cs,
   output logic              ram_cs,
   output logic              vram_cs,
   output logic              vram_attr,
   output logic              pio_cs,
   output logic              tmr_cs,
   output logic              ctl_cs,
   output logic              wr_inhibit,
   output logic              rd_valid
);
   localparam int ATTR_BIT = ADDR_W - 5;  // splits the 4 KB video area in halves

   generate
      if (ADDR_W != 16) begin : g_bad_aw
         $error("memmap_ctrl: ADDR_W must be 16");
      end
      if (CMD_BASE < 0 || CMD_BASE + NUM_CMDS > (1 << IO_W)) begin : g_bad_base
         $error("memmap_ctrl: command ports do not fit in IO_W");
      end
   endgenerate

   bank_state_t state;
   target_e     periph_tgt;
   target_e     tgt;

   memmap_bank_state #(.IO_W(IO_W), .CMD_BASE(CMD_BASE)) u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .io_wr   (io_wr),
      .io_port (io_port),
      .state   (state)
   );

   memmap_periph_dec #(.ADDR_W(ADDR_W), .PERIPH_MIRROR(PERIPH_MIRROR)) u_pdec (
      .addr (cpu_addr),
      .tgt  (periph_tgt)
   );

   memmap_region_dec #(.ADDR_W(ADDR_W)) u_rdec (
      .addr       (cpu_addr),
      .rd         (cpu_rd),
      .wr         (cpu_wr),
      .state      (state),
      .periph_tgt (periph_tgt),
      .tgt        (tgt)
   );

   assign rom_cs     = (tgt == TGT_ROM);
   assign ram_cs     = (tgt == TGT_RAM);
   assign vram_cs    = (tgt == TGT_VRAM);
   assign vram_attr  = vram_cs && cpu_addr[ATTR_BIT];
   assign pio_cs     = (tgt == TGT_PIO);
   assign tmr_cs     = (tgt == TGT_TMR);
   assign ctl_cs     = (tgt == TGT_CTL);
   assign wr_inhibit = cpu_wr && (tgt == TGT_NONE);
   assign rd_valid   = cpu_rd && (tgt != TGT_NONE);
endmodule

// File: rtl/memmap_ctrl_chk.sv
module memmap_ctrl_chk #(
   parameter int ADDR_W   = 16,
   parameter int IO_W     = 8,
   parameter int CMD_BASE = 'hE0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_rd,
   input logic              cpu_wr,
   input logic              io_wr,
   input logic [IO_W-1:0]   io_port,
   input logic              rom_cs,
   input logic              ram_cs,
   input logic              vram_cs,
   input logic              pio_cs,
   input logic              tmr_cs,
   input logic              ctl_cs,
   input logic              wr_inhibit,
   input logic              rd_valid
);
   localparam logic [IO_W-1:0] P_DEF  = IO_W'(CMD_BASE + 4);
   localparam logic [IO_W-1:0] P_LOCK = IO_W'(CMD_BASE + 5);

   logic       lk;
   logic [3:0] nib;
   logic       any_cs;
   assign nib    = cpu_addr[ADDR_W-1 -: 4];
   assign any_cs = rom_cs | ram_cs | vram_cs | pio_cs | tmr_cs | ctl_cs;

   always_ff @(posedge clk) begin
      if (!rst_n)                          lk <= 1'b0;
      else if (io_wr && io_port == P_DEF)  lk <= 1'b0;
      else if (io_wr && io_port == P_LOCK) lk <= 1'b1;
   end

   assert_one_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rom_cs, ram_cs, vram_cs, pio_cs, tmr_cs, ctl_cs}));

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_rd && !cpu_wr) |-> !any_cs);

   assert_low_write_ram_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && nib == 4'h0) |-> (ram_cs && !rom_cs));

   assert_mid_ram_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((cpu_rd || cpu_wr) && nib >= 4'h1 && nib <= 4'hC) |-> ram_cs);

   assert_lock_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lk && (cpu_rd || cpu_wr) && nib >= 4'hD) |-> (!any_cs && !rd_valid && (wr_inhibit == cpu_wr)));

   assert_restore_rom_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(io_wr && io_port == P_DEF) && cpu_rd && !cpu_wr && nib == 4'h0) |-> rom_cs);

   assert_hole_offsets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (nib >= 4'hE && cpu_addr[3:2] == 2'b11) |-> (!pio_cs && !tmr_cs && !ctl_cs));

   assert_valid_is_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (cpu_rd && any_cs));
endmodule

bind memmap_ctrl memmap_ctrl_chk #(.ADDR_W(ADDR_W), .IO_W(IO_W), .CMD_BASE(CMD_BASE)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_addr   (cpu_addr),
   .cpu_rd     (cpu_rd),
   .cpu_wr     (cpu_wr),
   .io_wr      (io_wr),
   .io_port    (io_port),
   .rom_cs     (rom_cs),
   .ram_cs     (ram_cs),
   .vram_cs    (vram_cs),
   .pio_cs     (pio_cs),
   .tmr_cs     (tmr_cs),
   .ctl_cs     (ctl_cs),
   .wr_inhibit (wr_inhibit),
   .rd_valid   (rd_valid)
);

// File: tb/memmap_ctrl_tb.sv
module memmap_ctrl_tb;
   localparam int BASE = 'hE0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_rd = 1'b0;
   logic        cpu_wr = 1'b0;
   logic        io_wr = 1'b0;
   logic [7:0]  io_port = '0;
   logic rom_cs, ram_cs, vram_cs, vram_attr, pio_cs, tmr_cs, ctl_cs, wr_inhibit, rd_valid;

   int n_vec = 0;
   int n_bad = 0;

   // bench model of the bank state
   bit m_rom = 1, m_dev = 1, m_lock = 0;

   always #5 clk = ~clk;

   memmap_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
      .io_wr(io_wr), .io_port(io_port), .rom_cs(rom_cs), .ram_cs(ram_cs), .vram_cs(vram_cs),
      .vram_attr(vram_attr), .pio_cs(pio_cs), .tmr_cs(tmr_cs), .ctl_cs(ctl_cs),
      .wr_inhibit(wr_inhibit), .rd_valid(rd_valid)
   );

   // vector order: rom ram vram attr pio tmr ctl wr_inhibit rd_valid
   function automatic logic [8:0] expect_of(input logic [15:0] a, input bit r, input bit w);
      bit rom = 0, ram = 0, vr = 0, at = 0, p = 0, t = 0, c = 0, any;
      if (r || w) begin
         if (a < 16'h1000)            begin if (!w && m_rom) rom = 1; else ram = 1; end
         else if (a < 16'hD000)       ram = 1;
         else if (m_lock)             ;
         else if (a < 16'hE000)       begin if (m_dev) begin vr = 1; at = a[11]; end else ram = 1; end
         else if (!m_dev)             ram = 1;
         else case (a[3:2])
            2'd0: p = 1;
            2'd1: t = 1;
            2'd2: c = 1;
            default: ;
         endcase
      end
      any = rom | ram | vr | p | t | c;
      return {rom, ram, vr, at, p, t, c, w && !any, r && any};
   endfunction

   function automatic string tag_of(input logic [15:0] a);
      if (a < 16'h1000) return "R2/R5";
      if (a < 16'hD000) return "R3";
      if (m_lock)       return "R7";
      if (a < 16'hE000) return "R6/R9";
      return "R4/R6";
   endfunction

   task automatic check(input string req);
      logic [8:0] got, exp;
      got = {rom_cs, ram_cs, vram_cs, vram_attr, pio_cs, tmr_cs, ctl_cs, wr_inhibit, rd_valid};
      exp = expect_of(cpu_addr, cpu_rd, cpu_wr);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s addr=%h rd=%0b wr=%0b actual=%b expected=%b", req, cpu_addr, cpu_rd, cpu_wr, got, exp);
      end
   endtask

   task automatic acc(input logic [15:0] a, input bit r, input bit w, input string req);
      @(negedge clk);
      cpu_addr = a; cpu_rd = r; cpu_wr = w;
      #2 check(req);
   endtask

   task automatic io(input logic [7:0] p);
      int o;
      @(negedge clk);
      cpu_rd = 0; cpu_wr = 0;
      io_wr = 1; io_port = p;
      @(negedge clk);
      io_wr = 0;
      o = int'(p) - BASE;
      case (o)
         0: m_rom = 0;
         2: m_rom = 1;
         1: if (!m_lock) m_dev = 0;
         3: if (!m_lock) m_dev = 1;
         4: begin m_rom = 1; m_dev = 1; m_lock = 0; end
         5: m_lock = 1;
         default: ;
      endcase
   endtask

   initial begin : watchdog
      #1ms;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h1357_2468));
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset map
      acc(16'h0042, 1, 0, "R1");
      acc(16'hD010, 1, 0, "R1");
      acc(16'hE000, 1, 0, "R1");
      // R11 idle
      acc(16'h0042, 0, 0, "R11");
      // R2 writes into low area while ROM is mapped
      acc(16'h0FFF, 0, 1, "R2");
      // R3
      acc(16'h1000, 1, 0, "R3");
      acc(16'hCFFF, 0, 1, "R3");
      // R4 offsets and mirror
      for (int k = 0; k < 16; k++) acc(16'hE000 + 16'(k), 1, 0, "R4");
      acc(16'hFFF4, 1, 0, "R4");
      acc(16'hF39B, 0, 1, "R4");
      acc(16'hE00C, 0, 1, "R4");
      acc(16'hE00F, 1, 0, "R12");
      // R9
      acc(16'hD7FF, 1, 0, "R9");
      acc(16'hD800, 0, 1, "R9");
      // R5
      io(8'(BASE + 0)); acc(16'h0100, 1, 0, "R5");
      io(8'(BASE + 2)); acc(16'h0100, 1, 0, "R5");
      // R6
      io(8'(BASE + 1)); acc(16'hD123, 1, 0, "R6"); acc(16'hE004, 1, 0, "R6");
      // R10 ignored ports
      io(8'(BASE + 6)); io(8'h03); io(8'(BASE + 7)); io(8'(BASE - 1));
      acc(16'hD000, 1, 0, "R10"); acc(16'h0001, 1, 0, "R10");
      io(8'(BASE + 3)); acc(16'hD123, 1, 0, "R6"); acc(16'hE008, 1, 0, "R6");
      // R7 lock, blocked upper commands, low commands still act
      io(8'(BASE + 5));
      acc(16'hD000, 1, 0, "R7"); acc(16'hE000, 0, 1, "R7"); acc(16'hFFFF, 1, 0, "R12");
      io(8'(BASE + 1)); acc(16'hD400, 1, 0, "R7");
      io(8'(BASE + 0)); acc(16'h0200, 1, 0, "R5");
      // R8 restore
      io(8'(BASE + 4));
      acc(16'h0200, 1, 0, "R8"); acc(16'hD400, 1, 0, "R8"); acc(16'hE005, 1, 0, "R8");
      // random mix
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(3) == 0) begin
            if ($urandom_range(1) == 0) io(8'(BASE + $urandom_range(7)));
            else                        io(8'($urandom_range(255)));
         end
         begin
            logic [15:0] a;
            int rw;
            a  = 16'($urandom_range(65535));
            rw = $urandom_range(3);
            if (m_lock == 0 && $urandom_range(3) == 0) a[15:13] = 3'b111;
            acc(a, rw == 0 || rw == 2, rw == 1, tag_of(a));
         end
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule